// File: doc/BRIEF.md
# Octal Low-Side Switch Diagnostic Controller

This block is the digital core of an eight-channel low-side switch driver. A host talks to it over an SPI slave port: each frame carries an 8-bit command word in, one bit per channel, and carries an 8-bit diagnostic word out at the same time. Four parallel inputs can also turn on channels 1 to 4 directly. The channel drive outputs are the OR of the serial command and the parallel inputs.

Each channel reports one digital flag from the analog side. The flag is high when the output voltage is below the reference level. The block compares this flag with the serially commanded state. An off channel whose output sits low is reported as an open load or a short to ground. An on channel whose output sits high is reported as an overload. Faults are latched and summarised on an active-low open-drain fault line, so the host only needs to read diagnostics when that line falls. The host reads the latched faults in the next frame, and that frame's chip-select release clears the faults it reported.

All SPI pins are oversampled by the system clock. The active-low reset is synchronous. It clears the command and the shift register and holds every output off.

Top module: `oct_switch_diag`

## Requirements
- R1: While `rst_n` is low, `ch_on`, `fault_pull` and `spi_miso_oe` are all 0. The serial command is cleared to all-off, and the parallel inputs have no effect.
- R2: `spi_miso_oe` is 0 whenever `spi_cs_n` is high and 1 while it is low. `spi_miso` is the data to drive while the enable is set.
- R3: `spi_mosi` is sampled on each `spi_sclk` rising edge. Diagnostic data leaves most significant bit (channel 8) first, and the next bit appears after each `spi_sclk` rising edge. The command word arrives MSB first too, so bit i controls channel i+1.
- R4: On the `spi_cs_n` rising edge, the received word becomes the new serial command only if exactly 8 `spi_sclk` rising edges were seen in the frame. Frames with fewer or more clocks leave the command unchanged.
- R5: `ch_on[i]` is the serial command bit i ORed with `par_on[i]` for i < 4. Bits 4 to 7 follow the serial command alone.
- R6: Each diagnostic bit equals the serial command bit of its channel when no fault is latched, and is its inverse when a fault is latched. The parallel inputs never take part in this encoding.
- R7: A channel is faulty when its serial command is off and `out_low` is 1 (open load or short to ground), or when its command is on and `out_low` is 0 (overload). Fault detection is suspended for SETTLE (default 16) clock cycles after every accepted command word.
- R8: A detected fault stays latched until the CS rising edge that ends a frame which reported it. `fault_pull` is 1 whenever any fault is latched.
- R9: The diagnostic word is captured on the CS falling edge. A fault that first appears during a frame is not in that frame's word, stays latched past its CS rising edge, and is reported in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset, forces all channels off |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_mosi | input | 1 | Serial command data in |
| spi_miso | output | 1 | Serial diagnostic data out |
| spi_miso_oe | output | 1 | Drive enable for spi_miso (0 = high impedance) |
| par_on | input | 4 | Parallel on-requests for channels 1 to 4 |
| out_low | input | 8 | Per channel: output voltage below reference |
| ch_on | output | 8 | Per-channel drive, 1 = switch on |
| fault_pull | output | 1 | Open-drain enable of the fault line, 1 = pull low |

## Verification
Command words with different bit patterns (A5, 3C, 00) are sent, so that any bit-order or echo error shows in the diagnostic word. Frames of 5 and 9 clocks tell an exact-count load apart from a load on any frame end. Pulsed overload and open-load faults on different channels tell inversion from echo, and they show whether the latch holds a fault after the flag is gone. A fault injected in the middle of a frame tells a falling-edge snapshot from a live read and shows that it is not cleared by the frame that missed it. A parallel request on a serially-off channel shows that the parallel path drives the channel but does not enter the diagnostic encoding.

// File: rtl/osd_pkg.sv
// Package: shared defaults for the octal switch diagnostic controller.
// Assumes: every module takes its widths from these defaults unless overridden.
package osd_pkg;
    localparam int CH_DEF     = 8;   // channels per device
    localparam int PAR_DEF    = 4;   // channels with a parallel on-request
    localparam int SETTLE_DEF = 16;  // fault blanking after a new command, cycles
endpackage

// File: rtl/osd_spi_sync.sv
// Module: osd_spi_sync
// Brings the asynchronous SPI pins into the clk domain through two flops
// and produces single-cycle edge strobes for chip select and serial clock.
// Assumes: clk runs at least 4x faster than spi_sclk.
module osd_spi_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    output logic cs_low,
    output logic cs_fall,
    output logic cs_rise,
    output logic sclk_rise,
    output logic mosi_s
);
    logic [1:0] cs_q, ck_q, di_q;
    logic       cs_d, ck_d;

    // Purpose: two-stage synchronisers plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= 2'b11;
            ck_q <= 2'b00;
            di_q <= 2'b00;
            cs_d <= 1'b1;
            ck_d <= 1'b0;
        end else begin
            cs_q <= {cs_q[0], cs_n};
            ck_q <= {ck_q[0], sclk};
            di_q <= {di_q[0], mosi};
            cs_d <= cs_q[1];
            ck_d <= ck_q[1];
        end
    end

    assign cs_low    = !cs_q[1];
    assign cs_fall   = cs_d && !cs_q[1];
    assign cs_rise   = !cs_d && cs_q[1];
    assign sclk_rise = !cs_q[1] && ck_q[1] && !ck_d;
    assign mosi_s    = di_q[1];
endmodule

// File: rtl/osd_spi_shift.sv
// Module: osd_spi_shift
// One shift register serves both directions: it loads the diagnostic word
// on CS fall, shifts MSB first on each SCLK rise, and hands the received word
// to the command register on CS rise if exactly NCH clocks were counted.
// Assumes: strobes come from osd_spi_sync (cs_rise and sclk_rise never coincide).
module osd_spi_shift #(
    parameter int NCH = osd_pkg::CH_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_fall,
    input  logic           cs_rise,
    input  logic           sclk_rise,
    input  logic           mosi_s,
    input  logic [NCH-1:0] diag_word,
    output logic           sh_msb,
    output logic [NCH-1:0] cmd,
    output logic           cmd_upd
);
    localparam int CW = $clog2(NCH + 2);
    localparam logic [CW-1:0] CNT_FULL = CW'(NCH);
    localparam logic [CW-1:0] CNT_OVER = CW'(NCH + 1);

    logic [NCH-1:0] sh;
    logic [CW-1:0]  cnt;

    assign cmd_upd = cs_rise && (cnt == CNT_FULL);
    assign sh_msb  = sh[NCH-1];

    // Purpose: snapshot, shift and count clocks within a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
        end else if (cs_fall) begin
            sh  <= diag_word;
            cnt <= '0;
        end else if (sclk_rise) begin
            sh <= {sh[NCH-2:0], mosi_s};
            if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
        end
    end

    // Purpose: accept the received word only on a frame of exact length.
    always_ff @(posedge clk) begin
        if (!rst_n)       cmd <= '0;
        else if (cmd_upd) cmd <= sh;
    end

    a_r4_bad_length_keeps_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && cnt != CNT_FULL) |=> $stable(cmd));
    a_r3_shift_takes_mosi: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && !cs_fall) |=> (sh[0] == $past(mosi_s)));
endmodule

// File: rtl/osd_fault_latch.sv
// Module: osd_fault_latch
// Classifies each channel from its serial command and output-level flag,
// latches faults, remembers which faults a frame reported, and clears only
// those on the frame's CS rise. Detection is blanked for SETTLE cycles
// after an accepted command so the output can move to its new level.
// Assumes: out_low is already synchronous to clk.
module osd_fault_latch #(
    parameter int NCH    = osd_pkg::CH_DEF,
    parameter int SETTLE = osd_pkg::SETTLE_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cmd,
    input  logic [NCH-1:0] out_low,
    input  logic           cmd_upd,
    input  logic           snap,
    input  logic           clr,
    output logic [NCH-1:0] diag_word,
    output logic           flt_any
);
    localparam int SW = $clog2(SETTLE + 1);
    localparam logic [SW-1:0] STL_INIT = SW'(SETTLE);

    logic [NCH-1:0] flt_lat, rep, open_ld, ovld, raw;
    logic [SW-1:0]  stl;
    logic           blank;

    assign blank   = (stl != '0);
    assign open_ld = ~cmd & out_low;
    assign ovld    = cmd & ~out_low;
    assign raw     = blank ? '0 : (open_ld | ovld);

    // Purpose: count down the blanking window after a new command.
    always_ff @(posedge clk) begin
        if (!rst_n)       stl <= STL_INIT;
        else if (cmd_upd) stl <= STL_INIT;
        else if (blank)   stl <= stl - 1'b1;
    end

    // Purpose: hold faults; release only those the finished frame reported.
    always_ff @(posedge clk) begin
        if (!rst_n) flt_lat <= '0;
        else        flt_lat <= (clr ? (flt_lat & ~rep) : flt_lat) | raw;
    end

    // Purpose: remember the faults captured into the outgoing word.
    always_ff @(posedge clk) begin
        if (!rst_n)    rep <= '0;
        else if (snap) rep <= flt_lat;
        else if (clr)  rep <= '0;
    end

    assign diag_word = cmd ^ flt_lat;
    assign flt_any   = |flt_lat;

    a_r8_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flt_lat & $past(flt_lat)) == $past(flt_lat)));
    a_r7_no_new_fault_when_blank: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> ((flt_lat & ~$past(flt_lat)) == '0));
endmodule

// File: rtl/oct_switch_diag.sv
// Module: oct_switch_diag (top)
// Joins the SPI synchroniser, the shift/command path and the fault latch,
// forms the channel drive from serial command and parallel requests, and
// drives the SPI data output and the open-drain fault enable.
// Assumes: a single clk domain; rst_n is synchronous and active low.
module oct_switch_diag #(
    parameter int NCH    = osd_pkg::CH_DEF,
    parameter int NPAR   = osd_pkg::PAR_DEF,
    parameter int SETTLE = osd_pkg::SETTLE_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            spi_cs_n,
    input  logic            spi_sclk,
    input  logic            spi_mosi,
    output logic            spi_miso,
    output logic            spi_miso_oe,
    input  logic [NPAR-1:0] par_on,
    input  logic [NCH-1:0]  out_low,
    output logic [NCH-1:0]  ch_on,
    output logic            fault_pull
);
    logic           cs_low, cs_fall, cs_rise, sclk_rise, mosi_s;
    logic           sh_msb, cmd_upd;
    logic [NCH-1:0] cmd, diag_word, par_ext;

    osd_spi_sync u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
        .cs_low(cs_low), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sclk_rise(sclk_rise), .mosi_s(mosi_s)
    );

    osd_spi_shift #(.NCH(NCH)) u_shift (
        .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sclk_rise(sclk_rise), .mosi_s(mosi_s), .diag_word(diag_word),
        .sh_msb(sh_msb), .cmd(cmd), .cmd_upd(cmd_upd)
    );

    osd_fault_latch #(.NCH(NCH), .SETTLE(SETTLE)) u_fault (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .out_low(out_low), .cmd_upd(cmd_upd),
        .snap(cs_fall), .clr(cs_rise), .diag_word(diag_word), .flt_any(fault_pull)
    );

    // Widen the parallel requests to channel width; upper channels get none.
    for (genvar i = 0; i < NCH; i++) begin : g_par
        if (i < NPAR) begin : g_on
            assign par_ext[i] = par_on[i];
        end else begin : g_off
            assign par_ext[i] = 1'b0;
        end
    end

    // Purpose: register the channel drive, forced off during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ch_on <= '0;
        else        ch_on <= cmd | par_ext;
    end

    assign spi_miso_oe = cs_low;
    assign spi_miso    = cs_low ? sh_msb : 1'b0;

    a_r2_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |-> !spi_miso_oe);
    a_r5_drive_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ch_on == ($past(cmd) | $past(par_ext))));
endmodule

// File: tb/oct_switch_diag_tb.sv
// Scoreboard bench: spi_xfer pushes the expected diagnostic word, the
// monitor pops it and compares with the word actually shifted out.
module oct_switch_diag_tb;
    logic       clk = 1'b0;
    logic       rst_n, cs_n, sclk, mosi;
    logic       miso, miso_oe, fault_pull;
    logic [3:0] par_on;
    logic [7:0] out_low, ch_on;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] exp_q[$];
    logic [7:0] rx_q[$];
    string      tag_q[$];
    bit         done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    oct_switch_diag u_dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe), .par_on(par_on), .out_low(out_low),
        .ch_on(ch_on), .fault_pull(fault_pull)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: one frame of nbits clocks; for 8-bit frames the expected
    // diagnostic word goes to the scoreboard. inj pulses out_low mid-frame.
    task automatic spi_xfer(input logic [7:0] tx, input int nbits, input logic [7:0] exp_diag,
                            input logic [7:0] new_low, input logic [7:0] inj, input string tag);
        logic [7:0] rx = '0;
        cs_n = 1'b0;
        clks(6);
        chk(miso_oe === 1'b1, "R2 oe while selected", miso_oe, 1);
        for (int b = 0; b < nbits; b++) begin
            mosi = (b < 8) ? tx[7-b] : 1'b0;
            clks(2);
            if (b < 8) rx[7-b] = miso;
            sclk = 1'b1;
            clks(4);
            sclk = 1'b0;
            if (b == 3 && inj != 8'h00) begin
                out_low = out_low ^ inj;
                clks(3);
                out_low = out_low ^ inj;
                clks(1);
            end else begin
                clks(4);
            end
        end
        cs_n = 1'b1;
        clks(6);
        out_low = new_low;
        clks(4);
        chk(miso_oe === 1'b0, "R2 high-Z when deselected", miso_oe, 0);
        if (nbits == 8) begin
            exp_q.push_back(exp_diag);
            tag_q.push_back(tag);
            rx_q.push_back(rx);
        end
        clks(20);
    endtask

    // Monitor: compare each shifted-out word with the expected one.
    initial begin
        forever begin
            @(negedge clk);
            if (rx_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] got, want;
                string t;
                got  = rx_q.pop_front();
                want = exp_q.pop_front();
                t    = tag_q.pop_front();
                chk(got == want, t, got, want);
            end
        end
    end

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0;
        par_on = 4'h0; out_low = 8'h00;
        clks(5);
        par_on = 4'hF;
        clks(3);
        chk(ch_on == 8'h00, "R1 reset channels off", ch_on, 0);
        chk(fault_pull == 1'b0, "R1 reset fault line idle", fault_pull, 0);
        chk(miso_oe == 1'b0, "R1 reset miso released", miso_oe, 0);
        par_on = 4'h0;
        rst_n = 1'b1;
        clks(20);

        // R4 R5: first write; diagnostics show reset command 00
        spi_xfer(8'hA5, 8, 8'h00, 8'hA5, 8'h00, "R1 diag after reset");
        chk(ch_on == 8'hA5, "R4 command applied", ch_on, 8'hA5);
        // R3 R6: healthy echo in MSB-first order
        spi_xfer(8'h3C, 8, 8'hA5, 8'h3C, 8'h00, "R3 R6 echo A5");
        chk(ch_on == 8'h3C, "R5 serial drive", ch_on, 8'h3C);
        chk(fault_pull == 1'b0, "R8 no fault healthy", fault_pull, 0);

        // R4: wrong frame lengths are ignored
        spi_xfer(8'hFF, 5, 8'h00, 8'h3C, 8'h00, "R4 short");
        chk(ch_on == 8'h3C, "R4 short frame ignored", ch_on, 8'h3C);
        spi_xfer(8'h81, 9, 8'h00, 8'h3C, 8'h00, "R4 long");
        chk(ch_on == 8'h3C, "R4 long frame ignored", ch_on, 8'h3C);

        // R7 R8: overload pulse on channel bit 2 (on, output high)
        out_low = 8'h38; clks(3); out_low = 8'h3C; clks(3);
        chk(fault_pull == 1'b1, "R8 overload latched", fault_pull, 1);
        spi_xfer(8'h3C, 8, 8'h38, 8'h3C, 8'h00, "R6 overload inverted");
        chk(fault_pull == 1'b0, "R8 cleared after report", fault_pull, 0);
        spi_xfer(8'h3C, 8, 8'h3C, 8'h3C, 8'h00, "R8 healthy after clear");

        // R7: open load pulse on bit 0 (off, output low)
        out_low = 8'h3D; clks(3); out_low = 8'h3C; clks(3);
        chk(fault_pull == 1'b1, "R7 open load latched", fault_pull, 1);
        spi_xfer(8'h3C, 8, 8'h3D, 8'h3C, 8'h00, "R7 open load reported");

        // R5 R6: parallel request drives the channel, diag follows serial bit
        par_on = 4'b1111; clks(3);
        chk(ch_on == 8'h3F, "R5 parallel OR", ch_on, 8'h3F);
        par_on = 4'b0001; out_low = 8'h3D; clks(3);
        chk(ch_on == 8'h3D, "R5 parallel channel 1", ch_on, 8'h3D);
        chk(fault_pull == 1'b1, "R6 serial-off channel flagged", fault_pull, 1);
        par_on = 4'b0000; out_low = 8'h3C; clks(3);
        spi_xfer(8'h3C, 8, 8'h3D, 8'h3C, 8'h00, "R6 serial bit governs diag");
        chk(fault_pull == 1'b0, "R8 cleared", fault_pull, 0);

        // R9: fault during a frame is kept for the next one
        spi_xfer(8'h3C, 8, 8'h3C, 8'h3C, 8'h80, "R9 frame misses mid fault");
        chk(fault_pull == 1'b1, "R9 mid-frame fault kept", fault_pull, 1);
        spi_xfer(8'h3C, 8, 8'hBC, 8'h3C, 8'h00, "R9 next frame reports");
        chk(fault_pull == 1'b0, "R9 cleared after report", fault_pull, 0);

        // R1: reset during operation
        par_on = 4'hF; rst_n = 1'b0; clks(3);
        out_low = 8'h00;
        chk(ch_on == 8'h00, "R1 reset forces off", ch_on, 0);
        chk(fault_pull == 1'b0, "R1 reset clears faults", fault_pull, 0);
        par_on = 4'h0; rst_n = 1'b1; clks(20);
        spi_xfer(8'h00, 8, 8'h00, 8'h00, 8'h00, "R1 command cleared");
        chk(ch_on == 8'h00, "R1 stays off", ch_on, 0);

        clks(5);
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule